// File: doc/BRIEF.md
# TDMA Cluster Cycle Scheduler

This block sequences one node's access to a time-triggered, time-division bus. A synchronised global time tick drives it. It counts ticks into slots, slots into rounds and rounds into a cluster cycle. Every round has the same slot timing, but each round can carry different frames. For each (round, slot) pair, a static schedule table says:

- which node owns the slot;
- whether the slot carries a data frame or a system frame;
- the frame identifier;
- whether frames received in that slot matter to this node.

The block uses only this table to decide when to transmit. At the start of each slot that this node owns, it raises a transmit request to both replicated channels. When a frame arrives in a slot that the table marks as relevant, it raises an accept strobe. Round-start and cycle-start pulses mark the schedule boundaries.

The schedule table is loaded while the scheduler is disabled. After enable, the scheduler waits for a start-of-cycle sync strobe. It then begins at round 0, slot 0 and repeats the cluster cycle for as long as it stays enabled.

Top module: `tdma_cluster_sched`

## Requirements
- R1: After reset or after `enable` rises, the scheduler stays idle (`running` low, no pulses) until `sync_start` is seen while enabled. The first slot after sync is round 0, slot 0, and its outputs appear two clock cycles after the edge that samples `sync_start`.
- R2: A slot lasts `slot_len` ticks (a value of 0 acts as 1). Slot and round indices change only on a clock edge where `tick` is high and the slot's last tick ends.
- R3: Slots run 0 to NSLOT-1 inside a round. After the last slot, the round index advances. After round NROUND-1, the schedule returns to round 0, slot 0.
- R4: When the slot owner equals `my_id`, `tx_req_a` and `tx_req_b` pulse together for exactly one cycle, two cycles after the slot begins. At the same time, `tx_kind` (0 = data frame, 1 = system frame) and `tx_fid` carry that entry's frame kind and identifier.
- R5: `round_start` pulses with the outputs of slot 0 of every round. `cycle_start` pulses only with the outputs of slot 0 of round 0.
- R6: `cur_round`, `cur_slot` and `slot_owner` hold the current slot's values for the whole slot.
- R7: `rx_accept` is high one cycle after a cycle with `rx_valid` high, only if the scheduler is running, the current slot's relevance bit is set and the slot owner is not `my_id`.
- R8: A schedule write (`cfg_we`, addressed by `cfg_round`/`cfg_slot`) takes effect only while `enable` is low. A write while enabled leaves the table unchanged.
- R9: Dropping `enable` clears `running` within two cycles and stops all pulses. A restart needs a new `sync_start`.
- R10: Reset clears `running`, all pulses, `cur_round`, `cur_slot`, `slot_owner`, `tx_kind` and `tx_fid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scheduler enable; table writable when low |
| tick | input | 1 | Global time tick, one cycle per tick |
| sync_start | input | 1 | Start-of-cycle sync strobe |
| slot_len | input | TICK_W | Ticks per slot |
| my_id | input | NID_W | This node's identifier |
| cfg_we | input | 1 | Schedule table write strobe |
| cfg_round | input | ROUND_W | Round index of the entry written |
| cfg_slot | input | SLOT_W | Slot index of the entry written |
| cfg_owner | input | NID_W | Owner id written |
| cfg_kind | input | 1 | Frame kind written (0 data, 1 system) |
| cfg_fid | input | FID_W | Frame identifier written |
| cfg_rx_rel | input | 1 | Receive-relevance bit written |
| rx_valid | input | 1 | A frame was received this cycle |
| running | output | 1 | Schedule is active |
| cur_round | output | ROUND_W | Current round index |
| cur_slot | output | SLOT_W | Current slot index |
| slot_owner | output | NID_W | Owner of the current slot |
| tx_req_a | output | 1 | Transmit request, channel A |
| tx_req_b | output | 1 | Transmit request, channel B |
| tx_kind | output | 1 | Frame kind of the current slot |
| tx_fid | output | FID_W | Frame identifier of the current slot |
| rx_accept | output | 1 | Received frame is relevant |
| round_start | output | 1 | First slot of a round |
| cycle_start | output | 1 | First slot of the cluster cycle |

## Verification
The assertions assume the following about the inputs:

- `my_id` stays constant while the scheduler runs.
- `tick` is a level sampled once per clock.
- The table holds at most one slot per round for this node.

The stimulus keeps `my_id` fixed at 2 and gives node 2 only slot 2 of each round. It changes `enable` and `slot_len` only between runs, and holds `sync_start` for exactly one cycle. Ticks are either continuous or isolated single pulses, so the slot-boundary cycles can be predicted exactly.

// File: rtl/tdma_sched_pkg.sv
package tdma_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_SYNC = 2'd1,
    ST_RUN       = 2'd2
  } sched_state_e;

  typedef enum logic {
    FT_DATA   = 1'b0,
    FT_SYSTEM = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table #(
  parameter int NID_W  = 4,
  parameter int FID_W  = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NID_W-1:0]  wr_owner,
  input  logic              wr_kind,
  input  logic [FID_W-1:0]  wr_fid,
  input  logic              wr_rx_rel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NID_W-1:0]  rd_owner,
  output logic              rd_kind,
  output logic [FID_W-1:0]  rd_fid,
  output logic              rd_rx_rel
);
  localparam int EW = NID_W + FID_W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_word;

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_owner, wr_kind, wr_fid, wr_rx_rel};
    rd_word <= mem[rd_addr];
  end

  assign rd_owner  = rd_word[EW-1 -: NID_W];
  assign rd_kind   = rd_word[FID_W+1];
  assign rd_fid    = rd_word[FID_W:1];
  assign rd_rx_rel = rd_word[0];
endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer
  import tdma_sched_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int NROUND  = 4,
  parameter int TICK_W  = 8,
  parameter int SLOT_W  = 2,
  parameter int ROUND_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               tick,
  input  logic               sync_start,
  input  logic [TICK_W-1:0]  slot_len,
  output logic               run,
  output logic               slot_begin,
  output logic [ROUND_W-1:0] round_idx,
  output logic [SLOT_W-1:0]  slot_idx
);
  localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(NSLOT - 1);
  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(NROUND - 1);

  sched_state_e       st;
  logic [TICK_W-1:0]  cnt;
  logic [SLOT_W-1:0]  slot_q;
  logic [ROUND_W-1:0] round_q;
  logic               begin_q;
  logic               slot_done;

  // last tick of the slot; slot_len of 0 behaves as 1
  assign slot_done = ({1'b0, cnt} + 1'b1) >= {1'b0, slot_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      slot_q  <= '0;
      round_q <= '0;
      begin_q <= 1'b0;
    end else begin
      begin_q <= 1'b0;
      if (!enable) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          ST_IDLE, ST_WAIT_SYNC: begin
            st <= ST_WAIT_SYNC;
            if (sync_start) begin
              st      <= ST_RUN;
              cnt     <= '0;
              slot_q  <= '0;
              round_q <= '0;
              begin_q <= 1'b1;
            end
          end
          ST_RUN: begin
            if (tick) begin
              if (slot_done) begin
                cnt     <= '0;
                begin_q <= 1'b1;
                if (slot_q == LAST_SLOT) begin
                  slot_q  <= '0;
                  round_q <= (round_q == LAST_ROUND) ? '0 : round_q + 1'b1;
                end else begin
                  slot_q <= slot_q + 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign run        = (st == ST_RUN);
  assign slot_begin = begin_q;
  assign round_idx  = round_q;
  assign slot_idx   = slot_q;

  AST_SLOT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && enable && !tick) |=> !begin_q); // R2
  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_RUN) |-> (begin_q && slot_q == '0 && round_q == '0)); // R1
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(slot_q) < NSLOT) && (int'(round_q) < NROUND)); // R3
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !begin_q); // R9
endmodule

// File: rtl/tdma_slot_decode.sv
module tdma_slot_decode
  import tdma_sched_pkg::*;
#(
  parameter int NID_W   = 4,
  parameter int FID_W   = 8,
  parameter int SLOT_W  = 2,
  parameter int ROUND_W = 2,
  parameter int NCH     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               slot_begin,
  input  logic [ROUND_W-1:0] round_idx,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic [NID_W-1:0]   my_id,
  input  logic [NID_W-1:0]   ent_owner,
  input  logic               ent_kind,
  input  logic [FID_W-1:0]   ent_fid,
  input  logic               ent_rx_rel,
  input  logic               rx_valid,
  output logic               running,
  output logic [ROUND_W-1:0] cur_round,
  output logic [SLOT_W-1:0]  cur_slot,
  output logic [NID_W-1:0]   slot_owner,
  output logic [NCH-1:0]     tx_req,
  output logic               tx_kind,
  output logic [FID_W-1:0]   tx_fid,
  output logic               rx_accept,
  output logic               round_start,
  output logic               cycle_start
);
  logic               begin_d;
  logic [ROUND_W-1:0] round_d;
  logic [SLOT_W-1:0]  slot_d;
  logic               rx_rel_q;
  frame_kind_e        kind_q;
  logic               own_now;

  // table read is one cycle behind the indices: delay them to line up
  always_ff @(posedge clk) begin
    if (rst) begin
      begin_d <= 1'b0;
      round_d <= '0;
      slot_d  <= '0;
    end else begin
      begin_d <= slot_begin;
      round_d <= round_idx;
      slot_d  <= slot_idx;
    end
  end

  assign own_now = run && begin_d && (ent_owner == my_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      cur_round   <= '0;
      cur_slot    <= '0;
      slot_owner  <= '0;
      kind_q      <= FT_DATA;
      tx_fid      <= '0;
      rx_rel_q    <= 1'b0;
      rx_accept   <= 1'b0;
      round_start <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      round_start <= 1'b0;
      cycle_start <= 1'b0;
      rx_accept   <= rx_valid && running && rx_rel_q && (slot_owner != my_id);
      if (!run) begin
        running <= 1'b0;
      end else if (begin_d) begin
        running     <= 1'b1;
        cur_round   <= round_d;
        cur_slot    <= slot_d;
        slot_owner  <= ent_owner;
        kind_q      <= frame_kind_e'(ent_kind);
        tx_fid      <= ent_fid;
        rx_rel_q    <= ent_rx_rel;
        round_start <= (slot_d == '0);
        cycle_start <= (slot_d == '0) && (round_d == '0);
      end
    end
  end

  assign tx_kind = kind_q;

  // one request flop per replicated channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) tx_req[ch] <= 1'b0;
      else     tx_req[ch] <= own_now;
    end
  end

  AST_CYCLE_IN_ROUND: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (round_start && cur_round == '0 && cur_slot == '0)); // R5
  AST_RX_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    rx_accept |-> $past(rx_valid)); // R7
  AST_RX_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    rx_accept |-> ($past(slot_owner) != my_id)); // R7
  AST_TX_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    tx_req[0] |-> (running && slot_owner == my_id)); // R4
endmodule

// File: rtl/tdma_cluster_sched.sv
module tdma_cluster_sched #(
  parameter int NID_W  = 4,
  parameter int FID_W  = 8,
  parameter int NSLOT  = 4,
  parameter int NROUND = 4,
  parameter int TICK_W = 8,
  localparam int SLOT_W  = (NSLOT  > 1) ? $clog2(NSLOT)  : 1,
  localparam int ROUND_W = (NROUND > 1) ? $clog2(NROUND) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               tick,
  input  logic               sync_start,
  input  logic [TICK_W-1:0]  slot_len,
  input  logic [NID_W-1:0]   my_id,
  input  logic               cfg_we,
  input  logic [ROUND_W-1:0] cfg_round,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [NID_W-1:0]   cfg_owner,
  input  logic               cfg_kind,
  input  logic [FID_W-1:0]   cfg_fid,
  input  logic               cfg_rx_rel,
  input  logic               rx_valid,
  output logic               running,
  output logic [ROUND_W-1:0] cur_round,
  output logic [SLOT_W-1:0]  cur_slot,
  output logic [NID_W-1:0]   slot_owner,
  output logic               tx_req_a,
  output logic               tx_req_b,
  output logic               tx_kind,
  output logic [FID_W-1:0]   tx_fid,
  output logic               rx_accept,
  output logic               round_start,
  output logic               cycle_start
);
  localparam int DEPTH  = NSLOT * NROUND;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NCH    = 2;

  logic               run;
  logic               slot_begin;
  logic [ROUND_W-1:0] round_idx;
  logic [SLOT_W-1:0]  slot_idx;
  logic [ADDR_W-1:0]  rd_addr;
  logic [ADDR_W-1:0]  wr_addr;
  logic               wr_ok;
  logic [NID_W-1:0]   ent_owner;
  logic               ent_kind;
  logic [FID_W-1:0]   ent_fid;
  logic               ent_rx_rel;
  logic [NCH-1:0]     tx_req;

  always_comb begin
    rd_addr = ADDR_W'(int'(round_idx) * NSLOT + int'(slot_idx));
    wr_addr = ADDR_W'(int'(cfg_round) * NSLOT + int'(cfg_slot));
    wr_ok   = cfg_we && !enable && (int'(cfg_slot) < NSLOT) && (int'(cfg_round) < NROUND);
  end

  tdma_slot_timer #(
    .NSLOT(NSLOT), .NROUND(NROUND), .TICK_W(TICK_W),
    .SLOT_W(SLOT_W), .ROUND_W(ROUND_W)
  ) u_timer (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .sync_start(sync_start), .slot_len(slot_len),
    .run(run), .slot_begin(slot_begin),
    .round_idx(round_idx), .slot_idx(slot_idx)
  );

  tdma_sched_table #(
    .NID_W(NID_W), .FID_W(FID_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .wr_en(wr_ok), .wr_addr(wr_addr),
    .wr_owner(cfg_owner), .wr_kind(cfg_kind), .wr_fid(cfg_fid),
    .wr_rx_rel(cfg_rx_rel), .rd_addr(rd_addr),
    .rd_owner(ent_owner), .rd_kind(ent_kind), .rd_fid(ent_fid),
    .rd_rx_rel(ent_rx_rel)
  );

  tdma_slot_decode #(
    .NID_W(NID_W), .FID_W(FID_W), .SLOT_W(SLOT_W),
    .ROUND_W(ROUND_W), .NCH(NCH)
  ) u_decode (
    .clk(clk), .rst(rst), .run(run), .slot_begin(slot_begin),
    .round_idx(round_idx), .slot_idx(slot_idx), .my_id(my_id),
    .ent_owner(ent_owner), .ent_kind(ent_kind), .ent_fid(ent_fid),
    .ent_rx_rel(ent_rx_rel), .rx_valid(rx_valid),
    .running(running), .cur_round(cur_round), .cur_slot(cur_slot),
    .slot_owner(slot_owner), .tx_req(tx_req), .tx_kind(tx_kind),
    .tx_fid(tx_fid), .rx_accept(rx_accept),
    .round_start(round_start), .cycle_start(cycle_start)
  );

  assign tx_req_a = tx_req[0];
  assign tx_req_b = tx_req[1];
endmodule

// File: tb/tdma_cluster_sched_bench.sv
module tdma_cluster_sched_bench;
  localparam int NID_W = 4, FID_W = 8, NSLOT = 4, NROUND = 4, TICK_W = 8;
  localparam int MY = 2;
  localparam int NVEC = 20;
  // vector: [4:3] expected round, [2:1] expected slot, [0] drive rx_valid
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00001, 5'b00011, 5'b00101, 5'b00110,
    5'b01001, 5'b01010, 5'b01101, 5'b01111,
    5'b10001, 5'b10011, 5'b10100, 5'b10111,
    5'b11000, 5'b11011, 5'b11101, 5'b11111,
    5'b00001, 5'b00010, 5'b00101, 5'b00111
  };

  logic clk = 1'b0;
  logic rst, enable, tick, sync_start, cfg_we, cfg_kind, cfg_rx_rel, rx_valid;
  logic [TICK_W-1:0] slot_len;
  logic [NID_W-1:0] my_id, cfg_owner, slot_owner;
  logic [1:0] cfg_round, cfg_slot, cur_round, cur_slot;
  logic [FID_W-1:0] cfg_fid, tx_fid;
  logic running, tx_req_a, tx_req_b, tx_kind, rx_accept, round_start, cycle_start;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tdma_cluster_sched #(.NID_W(NID_W), .FID_W(FID_W), .NSLOT(NSLOT),
                       .NROUND(NROUND), .TICK_W(TICK_W)) u_tdma_cluster_sched (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .sync_start(sync_start),
    .slot_len(slot_len), .my_id(my_id), .cfg_we(cfg_we), .cfg_round(cfg_round),
    .cfg_slot(cfg_slot), .cfg_owner(cfg_owner), .cfg_kind(cfg_kind),
    .cfg_fid(cfg_fid), .cfg_rx_rel(cfg_rx_rel), .rx_valid(rx_valid),
    .running(running), .cur_round(cur_round), .cur_slot(cur_slot),
    .slot_owner(slot_owner), .tx_req_a(tx_req_a), .tx_req_b(tx_req_b),
    .tx_kind(tx_kind), .tx_fid(tx_fid), .rx_accept(rx_accept),
    .round_start(round_start), .cycle_start(cycle_start));

  function automatic int e_owner(int r, int s); return s; endfunction
  function automatic int e_kind(int r, int s); return (r + s) % 2; endfunction
  function automatic int e_fid(int r, int s); return r * 16 + s + 1; endfunction
  function automatic int e_rel(int r, int s); return ((r + s) % 3 != 0) ? 1 : 0; endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_entry(int r, int s, int own, int kind, int fid, int rel);
    cfg_we = 1'b1; cfg_round = 2'(r); cfg_slot = 2'(s); cfg_owner = 4'(own);
    cfg_kind = 1'(kind); cfg_fid = 8'(fid); cfg_rx_rel = 1'(rel);
    cyc(1);
    cfg_we = 1'b0;
  endtask

  // sync pulse; returns at the negedge where slot 0 outputs are visible
  task automatic do_sync();
    sync_start = 1'b1;
    cyc(1);
    sync_start = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; tick = 1'b0; sync_start = 1'b0; cfg_we = 1'b0;
    cfg_kind = 1'b0; cfg_rx_rel = 1'b0; rx_valid = 1'b0; slot_len = 8'd3;
    my_id = 4'(MY); cfg_owner = '0; cfg_round = '0; cfg_slot = '0; cfg_fid = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R10 reset state
    check("R10", "running", running, 0);
    check("R10", "tx_req_a", tx_req_a, 0);
    check("R10", "cur_slot", cur_slot, 0);
    check("R10", "slot_owner", slot_owner, 0);
    check("R10", "tx_fid", tx_fid, 0);
    check("R10", "round_start", round_start, 0);

    for (int r = 0; r < NROUND; r++)
      for (int s = 0; s < NSLOT; s++)
        wr_entry(r, s, e_owner(r, s), e_kind(r, s), e_fid(r, s), e_rel(r, s));

    // R1: enabled but no sync -> idle
    enable = 1'b1; tick = 1'b1;
    cyc(6);
    check("R1", "running before sync", running, 0);
    check("R1", "tx before sync", tx_req_a, 0);
    do_sync();

    for (int k = 0; k < NVEC; k++) begin
      int r, s, tx, rx;
      r = int'(VEC[k][4:3]); s = int'(VEC[k][2:1]); rx = int'(VEC[k][0]);
      tx = (e_owner(r, s) == MY) ? 1 : 0;
      check("R1", "running", running, 1);
      check("R3", "cur_round", cur_round, r);
      check("R3", "cur_slot", cur_slot, s);
      check("R6", "slot_owner", slot_owner, e_owner(r, s));
      check("R4", "tx_req_a", tx_req_a, tx);
      check("R4", "tx_req_b", tx_req_b, tx);
      if (tx == 1) begin
        check("R4", "tx_kind", tx_kind, e_kind(r, s));
        check("R4", "tx_fid", tx_fid, e_fid(r, s));
      end
      check("R5", "round_start", round_start, (s == 0) ? 1 : 0);
      check("R5", "cycle_start", cycle_start, (s == 0 && r == 0) ? 1 : 0);
      rx_valid = 1'(rx);
      cyc(1);
      rx_valid = 1'b0;
      check("R7", "rx_accept", rx_accept,
            (rx == 1 && e_rel(r, s) == 1 && e_owner(r, s) != MY) ? 1 : 0);
      check("R4", "tx pulse width", tx_req_a, 0);
      check("R6", "cur_slot held", cur_slot, s);
      check("R6", "owner held", slot_owner, e_owner(r, s));
      cyc(2);
    end

    // R8: write while enabled is ignored
    wr_entry(0, 2, MY, 1, 8'hEE, 0);
    // R9: disable stops the schedule
    enable = 1'b0;
    cyc(2);
    check("R9", "running after disable", running, 0);
    cyc(6);
    check("R9", "tx while disabled", tx_req_a, 0);

    // R2: tick gating with slot_len of 1
    slot_len = 8'd1; tick = 1'b0; enable = 1'b1;
    cyc(3);
    check("R9", "no restart without sync", running, 0);
    do_sync();
    check("R1", "start slot", cur_slot, 0);
    check("R1", "start cycle pulse", cycle_start, 1);
    cyc(8);
    check("R2", "slot held without ticks", cur_slot, 0);
    check("R2", "no extra round_start", round_start, 0);
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
    cyc(2);
    check("R2", "advance on tick", cur_slot, 1);
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
    cyc(2);
    check("R2", "second tick slot", cur_slot, 2);
    check("R8", "own tx after ignored write", tx_req_a, 1);
    check("R8", "fid unchanged", tx_fid, e_fid(0, 2));

    // R8: write while disabled takes effect
    enable = 1'b0;
    cyc(2);
    wr_entry(0, 0, MY, 1, 8'h55, 0);
    enable = 1'b1;
    cyc(2);
    do_sync();
    check("R8", "tx on rewritten slot", tx_req_a, 1);
    check("R8", "rewritten fid", tx_fid, 8'h55);
    check("R4", "system kind", tx_kind, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule